// File: doc/BRIEF.md
# Power-Management Control and Wake Status Register

This block is the power-management control and status register of a network controller, together with the sequencing logic behind it. A host reaches it over a simple register bus (address, write strobe, write data, combinational read data). Through it software selects a power state, pulses a PHY reset, enables the two wake causes (a wake-on-LAN detector and an energy detector), reads and clears the latched wake cause, and configures how the PME pin is driven.

The PHY reset is a self-timed pulse. Writing the reset bit starts a hold counter sized from the clock frequency and a hold time in microseconds. The bit reads 1 for the whole hold, then clears itself, and further writes to it are ignored while it is set. In either low-power state the control register is locked and reports not-ready. The only way back to full power is a write of any value to a separate wake register. The wake status is sticky. A wake status bit is cleared by writing 1 to it from full power, but it sets again at once if its detector still reports its event.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x400. The fields are: bits[1:0] power state, bit2 PHY reset, bit3 wake-on-LAN enable, bit4 energy enable, bit5 PME pin enable, bit6 push-pull select, bit7 active-high polarity, bits[9:8] wake status, bit10 ready. After reset `phyRstN` is 1, `pmeIrq` is 0 and `pmeOe` is 0.
- R2: A control write from full power loads the power state with 00 (full), 01 (light sleep) or 10 (deep sleep). A write of 11 leaves the state unchanged, while the other fields of the same write still take effect.
- R3: A write of any data to the wake register (address 1) returns the power state to 00 and sets ready.
- R4: Ready reads 0 whenever the power state is not 00. While ready is 0, writes to the control register change no field.
- R5: Writing 1 to bit2 drives `phyRstN` low for exactly HOLD_CYC cycles, where HOLD_CYC = CLK_HZ/1e6 × HOLD_US (12 in the bench). Bit2 reads 1 during the hold and 0 after it.
- R6: A write of 1 to bit2 while bit2 reads 1 neither restarts nor lengthens the hold.
- R7: Wake status bit8 sets when the energy detector reports pending with its enable set. Bit9 sets the same way from the wake-on-LAN detector. Status 11 means both causes occurred.
- R8: `pmeIrq` is 1 while any wake status bit is set, regardless of the pin enable. A cause whose enable is 0 sets no status.
- R9: The PME pin is asserted only when the pin enable is 1 and a wake status bit is set.
- R10: With push-pull select 0 the pin is open-drain and active low: `pmeOut` is 0 and `pmeOe` equals the asserted level, whatever the polarity bit holds. With push-pull select 1, `pmeOe` is 1 and `pmeOut` is the asserted level when polarity is 1, and its inverse when polarity is 0.
- R11: Writing 1 to a status bit clears it only in full power, and only if its detector no longer reports pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` |
| wolPend | input | 1 | Wake-on-LAN detector has a pending event |
| edPend | input | 1 | Energy detector has a pending event |
| phyRstN | output | 1 | Active-low PHY reset |
| pmeIrq | output | 1 | Wake interrupt |
| pmeOut | output | 1 | PME pin data |
| pmeOe | output | 1 | PME pin output enable |

## Verification
The assertions take for granted that the detector pending inputs are synchronous levels that stay high until the source is serviced. They also assume a write lasts one cycle with a stable address. The stimulus drives every input on the falling edge, raises each pending line for whole cycles, and drops it before any clear attempt that is meant to succeed. The locked-register checks are made only after a state change has settled, so each one observes a single stable power state.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

  typedef enum logic [1:0] {
    PM_FULL  = 2'b00,
    PM_LIGHT = 2'b01,
    PM_DEEP  = 2'b10,
    PM_RSVD  = 2'b11
  } pm_mode_e;

  localparam int F_MODE_LO = 0;
  localparam int F_PHY     = 2;
  localparam int F_WOL_EN  = 3;
  localparam int F_ED_EN   = 4;
  localparam int F_PIN_EN  = 5;
  localparam int F_PUSH    = 6;
  localparam int F_POL     = 7;
  localparam int F_STAT_LO = 8;
  localparam int F_READY   = 10;
  localparam int CTL_BITS  = 11;

  typedef struct packed {
    logic wolEn;
    logic edEn;
    logic pinEn;
    logic pushPull;
    logic polHigh;
  } pm_cfg_t;

  typedef struct packed {
    logic [1:0] clrWake;
    logic       ready;
    pm_cfg_t    cfg;
  } pm_strobe_t;

endpackage

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl
  import pm_wake_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = '0,
  parameter logic [ADDR_W-1:0] WAKE_ADDR = 1,
  parameter logic [DATA_W-1:0] WAKE_VALUE = '0,
  parameter int HOLD_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [1:0]        wakeStatus,
  output pm_strobe_t        strobe,
  output logic              phyRstN
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

  pm_mode_e         modeQ;
  pm_cfg_t          cfgQ;
  logic             phyBusyQ;
  logic [CNT_W-1:0] holdCntQ;

  logic ctlHit, wakeHit, isReady, ctlWr;

  assign ctlHit  = (addr == CTL_ADDR);
  assign wakeHit = (addr == WAKE_ADDR);
  assign isReady = (modeQ == PM_FULL);
  assign ctlWr   = wrEn && ctlHit && isReady;

  // power state: wake register has priority, reserved code is refused
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= PM_FULL;
    end else if (wrEn && wakeHit) begin
      modeQ <= PM_FULL;
    end else if (ctlWr && (wrData[F_MODE_LO+1:F_MODE_LO] != PM_RSVD)) begin
      modeQ <= pm_mode_e'(wrData[F_MODE_LO+1:F_MODE_LO]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (ctlWr) begin
      cfgQ.wolEn    <= wrData[F_WOL_EN];
      cfgQ.edEn     <= wrData[F_ED_EN];
      cfgQ.pinEn    <= wrData[F_PIN_EN];
      cfgQ.pushPull <= wrData[F_PUSH];
      cfgQ.polHigh  <= wrData[F_POL];
    end
  end

  // self-timed PHY reset; writes are not looked at while busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyBusyQ <= 1'b0;
      holdCntQ <= '0;
    end else if (phyBusyQ) begin
      if (holdCntQ == '0) begin
        phyBusyQ <= 1'b0;
      end else begin
        holdCntQ <= holdCntQ - 1'b1;
      end
    end else if (ctlWr && wrData[F_PHY]) begin
      phyBusyQ <= 1'b1;
      holdCntQ <= CNT_LOAD;
    end
  end

  assign phyRstN = !phyBusyQ;

  always_comb begin
    strobe.cfg     = cfgQ;
    strobe.ready   = isReady;
    strobe.clrWake = ctlWr ? wrData[F_STAT_LO+1:F_STAT_LO] : 2'b00;
  end

  always_comb begin
    rdData = '0;
    if (ctlHit) begin
      rdData[F_MODE_LO+1:F_MODE_LO] = modeQ;
      rdData[F_PHY]                 = phyBusyQ;
      rdData[F_WOL_EN]              = cfgQ.wolEn;
      rdData[F_ED_EN]               = cfgQ.edEn;
      rdData[F_PIN_EN]              = cfgQ.pinEn;
      rdData[F_PUSH]                = cfgQ.pushPull;
      rdData[F_POL]                 = cfgQ.polHigh;
      rdData[F_STAT_LO+1:F_STAT_LO] = wakeStatus;
      rdData[F_READY]               = isReady;
    end else if (wakeHit) begin
      rdData = WAKE_VALUE;
    end
  end

  // checker state: length of the current reset pulse
  logic [CNT_W:0] busyRunQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRunQ <= '0;
    else       busyRunQ <= phyBusyQ ? busyRunQ + 1'b1 : '0;
  end

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeQ != PM_RSVD);

  p_wake_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wakeHit) |=> (modeQ == PM_FULL));

  p_locked_ctl_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ctlHit && !wakeHit && modeQ != PM_FULL) |=> ($stable(cfgQ) && $stable(modeQ)));

  p_hold_length_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyBusyQ) |-> (busyRunQ == (CNT_W+1)'(HOLD_CYC)));

  p_hold_no_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phyBusyQ && holdCntQ != '0) |=> (phyBusyQ && holdCntQ == $past(holdCntQ) - 1'b1));

endmodule

// File: rtl/pm_wake_dp.sv
module pm_wake_dp
  import pm_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pm_strobe_t strobe,
  input  logic       wolPend,
  input  logic       edPend,
  output logic [1:0] wakeStatus,
  output logic       pmeIrq,
  output logic       pmeOut,
  output logic       pmeOe
);

  logic [1:0] statusQ;
  logic [1:0] setReq;
  logic       pinActive;

  // bit0 energy, bit1 wake-on-LAN; set wins over clear
  assign setReq = {wolPend && strobe.cfg.wolEn, edPend && strobe.cfg.edEn};

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_cause
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          statusQ[k] <= 1'b0;
        else if (setReq[k]) statusQ[k] <= 1'b1;
        else if (strobe.clrWake[k]) statusQ[k] <= 1'b0;
      end
    end
  endgenerate

  assign wakeStatus = statusQ;
  assign pmeIrq     = |statusQ;
  assign pinActive  = strobe.cfg.pinEn && (|statusQ);

  always_comb begin
    if (strobe.cfg.pushPull) begin
      pmeOe  = 1'b1;
      pmeOut = strobe.cfg.polHigh ? pinActive : !pinActive;
    end else begin
      pmeOe  = pinActive;
      pmeOut = 1'b0;
    end
  end

  p_sticky_lowpower_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ready) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  p_disabled_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cfg.wolEn && !statusQ[1]) |=> !statusQ[1]);

  p_opendrain_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cfg.pushPull) |-> (pmeOut == 1'b0));

  p_pin_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cfg.pinEn && !strobe.cfg.pushPull) |-> !pmeOe);

endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_wake_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int CLK_HZ  = 100_000_000,
  parameter int HOLD_US = 100,
  parameter logic [DATA_W-1:0] WAKE_VALUE = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              wolPend,
  input  logic              edPend,
  output logic              phyRstN,
  output logic              pmeIrq,
  output logic              pmeOut,
  output logic              pmeOe
);

  localparam int RAW_CYC  = (CLK_HZ / 1_000_000) * HOLD_US;
  localparam int HOLD_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  pm_strobe_t strobe;
  logic [1:0] wakeStatus;

  pm_wake_ctl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTL_ADDR  (ADDR_W'(0)),
    .WAKE_ADDR (ADDR_W'(1)),
    .WAKE_VALUE(WAKE_VALUE),
    .HOLD_CYC  (HOLD_CYC)
  ) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .rdData    (rdData),
    .wakeStatus(wakeStatus),
    .strobe    (strobe),
    .phyRstN   (phyRstN)
  );

  pm_wake_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wolPend   (wolPend),
    .edPend    (edPend),
    .wakeStatus(wakeStatus),
    .pmeIrq    (pmeIrq),
    .pmeOut    (pmeOut),
    .pmeOe     (pmeOe)
  );

endmodule

// File: tb/pm_wake_ctrl_tb_top.sv
module pm_wake_ctrl_tb_top;

  localparam int HOLD = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        wolPend = 1'b0;
  logic        edPend = 1'b0;
  logic        phyRstN, pmeIrq, pmeOut, pmeOe;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  logic [15:0] maskQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pm_wake_ctrl #(.CLK_HZ(1_000_000), .HOLD_US(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .wolPend(wolPend), .edPend(edPend), .phyRstN(phyRstN),
    .pmeIrq(pmeIrq), .pmeOut(pmeOut), .pmeOe(pmeOe)
  );

  // monitor: pops expected read items and compares against the bus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [15:0] e, m;
        string t;
        e = expQ.pop_front();
        m = maskQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ((rdData & m) !== e) begin
          fails++;
          $display("FAIL %s: read got 0x%h expected 0x%h", t, rdData & m, e);
        end
      end
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readExp(input logic [3:0] a, input logic [15:0] m,
                         input logic [15:0] e, input string t);
    @(negedge clk);
    wrEn = 1'b0; addr = a;
    expQ.push_back(e); maskQ.push_back(m); tagQ.push_back(t);
    @(posedge clk);
    #3;
  endtask

  task automatic checkPin(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", t, act, exp);
    end
  endtask

  task automatic pulse(input bit wol, input bit ed);
    @(negedge clk);
    wolPend = wol; edPend = ed;
    @(negedge clk);
    wolPend = 1'b0; edPend = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int startCyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readExp(0, 16'h07FF, 16'h0400, "R1 ctl reset");
    checkPin("R1 phyRstN", phyRstN, 1'b1);
    checkPin("R1 pmeIrq", pmeIrq, 1'b0);
    checkPin("R1 pmeOe", pmeOe, 1'b0);

    // R5 / R6 PHY reset hold
    regWrite(0, 16'h0004);
    startCyc = cyc;
    readExp(0, 16'h0004, 16'h0004, "R5 bit reads 1 in hold");
    regWrite(0, 16'h0004);
    while (phyRstN !== 1'b1) @(negedge clk);
    checks++;
    if (cyc - startCyc != HOLD) begin
      fails++;
      $display("FAIL R5 R6: hold got %0d expected %0d", cyc - startCyc, HOLD);
    end
    readExp(0, 16'h0004, 16'h0000, "R5 bit self-clears");

    // R2 reserved state refused, other fields taken
    regWrite(0, 16'h000B);
    readExp(0, 16'h07FF, 16'h0408, "R2 reserved state");

    // R7 / R10 energy cause, push-pull active low
    regWrite(0, 16'h0078);
    @(negedge clk); edPend = 1'b1;
    @(negedge clk);
    readExp(0, 16'h07FF, 16'h0578, "R7 energy status");
    checkPin("R8 irq on energy", pmeIrq, 1'b1);
    checkPin("R10 push-pull oe", pmeOe, 1'b1);
    checkPin("R10 push-pull low active", pmeOut, 1'b0);
    // R11 clear refused while detector still pending
    regWrite(0, 16'h0178);
    readExp(0, 16'h0300, 16'h0100, "R11 pending blocks clear");
    @(negedge clk); edPend = 1'b0;
    regWrite(0, 16'h0178);
    readExp(0, 16'h0300, 16'h0000, "R11 clear in full power");
    checkPin("R8 irq cleared", pmeIrq, 1'b0);
    checkPin("R10 push-pull idle high", pmeOut, 1'b1);

    // R7 both causes
    pulse(1'b1, 1'b1);
    readExp(0, 16'h0300, 16'h0300, "R7 both causes");
    regWrite(0, 16'h0378);
    readExp(0, 16'h0300, 16'h0000, "R11 clear both");

    // R9 pin disabled, irq still raised
    regWrite(0, 16'h0018);
    pulse(1'b1, 1'b0);
    readExp(0, 16'h0300, 16'h0200, "R7 wake cause");
    checkPin("R8 irq without pin", pmeIrq, 1'b1);
    checkPin("R9 pin gated", pmeOe, 1'b0);
    regWrite(0, 16'h0218);

    // R8 disabled cause sets nothing
    regWrite(0, 16'h0010);
    pulse(1'b1, 1'b0);
    readExp(0, 16'h0300, 16'h0000, "R8 disabled cause");
    checkPin("R8 no irq", pmeIrq, 1'b0);

    // R10 open-drain ignores polarity
    regWrite(0, 16'h00A8);
    checkPin("R10 od idle oe", pmeOe, 1'b0);
    pulse(1'b1, 1'b0);
    checkPin("R10 od oe", pmeOe, 1'b1);
    checkPin("R10 od out low", pmeOut, 1'b0);
    regWrite(0, 16'h02A8);
    checkPin("R10 od released", pmeOe, 1'b0);

    // R10 push-pull active high
    regWrite(0, 16'h00E8);
    checkPin("R10 pp high idle", pmeOut, 1'b0);
    pulse(1'b1, 1'b0);
    checkPin("R10 pp high active", pmeOut, 1'b1);
    regWrite(0, 16'h02E8);

    // R4 / R11 light sleep lock
    regWrite(0, 16'h0019);
    readExp(0, 16'h07FF, 16'h0019, "R4 light sleep not ready");
    pulse(1'b1, 1'b0);
    readExp(0, 16'h07FF, 16'h0219, "R7 wake in light sleep");
    regWrite(0, 16'h0200);
    readExp(0, 16'h07FF, 16'h0219, "R4 R11 locked write ignored");
    // R3 wake register
    regWrite(1, 16'h0000);
    readExp(0, 16'h07FF, 16'h0618, "R3 wake from light sleep");
    regWrite(0, 16'h0218);
    readExp(0, 16'h07FF, 16'h0418, "R11 clear after wake");

    // R2 / R3 deep sleep
    regWrite(0, 16'h0012);
    readExp(0, 16'h07FF, 16'h0012, "R2 deep sleep");
    regWrite(1, 16'hFFFF);
    readExp(0, 16'h07FF, 16'h0410, "R3 wake from deep sleep");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule